// File: doc/BRIEF.md
# SDRAM Read-Latency and Byte-Lane Mask Pipeline

This block models the cycle timing of the data side of a 16-bit synchronous DRAM port. A read strobe arrives together with the word fetched from the array. The block holds that word back by the programmed column latency of two or three clocks. It then presents the word with a valid flag and one output-enable per byte lane. Two byte-mask inputs, one for each half of the word, act on reads two clocks after they are sampled. On writes they act in the same cycle, where they gate a pair of combinational write enables.

The latency comes in as a 3-bit code. Only two codes are legal. The block takes a legal code only while no read is in flight, so a burst never changes latency partway through. An illegal code raises an error flag and leaves the latency that was already in force.

A read-side model or a controller testbench uses the block in front of its storage array. It marks each beat of a burst with the read strobe on consecutive clocks and samples the data on the clock after it is presented.

Top module: `sdram_dq_pipe`

## Requirements
- R1: While reset is active and after it, `rd_valid_o`, `rd_lane_oe_o`, `rd_data_o` and `cas_err_o` are zero, and the latency in force is two clocks until a legal code is taken.
- R2: With latency two (code 3'b010), a strobe sampled at edge n loads the word into `rd_data_o` with `rd_valid_o` high at edge n+1, so a receiver captures it at edge n+2.
- R3: With latency three (code 3'b011), a strobe sampled at edge n is presented from edge n+2 and captured at edge n+3. It is not presented earlier.
- R4: A lane enable (`rd_lane_oe_o[0]` for bits 7:0, `[1]` for bits 15:8) rises at the same edge the word is loaded, one edge before capture. It is low in every cycle without a presented beat.
- R5: Strobes on consecutive clocks give one presented word per clock, in order, with the valid flag and the unmasked enables held high across the whole burst.
- R6: A read mask bit high when sampled at edge k turns off its lane's enable and forces that lane's data bits to zero in the cycle loaded at edge k+2. The other lane is unaffected.
- R7: `wr_lane_en_o[0]` equals `wr_strobe_i & ~dqm_lo_i` and `wr_lane_en_o[1]` equals `wr_strobe_i & ~dqm_hi_i`, in the same cycle.
- R8: A code other than 3'b010 or 3'b011 sampled at an edge sets `cas_err_o` after that edge and leaves the latency unchanged.
- R9: The latency code is taken only at an edge where no strobe is present and no beat is in flight. A code changed during a burst takes effect for reads issued after the pipeline drains.
- R10: A legal code sampled at an edge clears `cas_err_o` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all registers use its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| cas_code_i | input | 3 | Latency code: 3'b010 selects two clocks, 3'b011 selects three |
| rd_strobe_i | input | 1 | One read beat registered at this edge |
| arr_rdata_i | input | 16 | Array word belonging to the read beat |
| wr_strobe_i | input | 1 | One write beat in this cycle |
| dqm_lo_i | input | 1 | Mask for bits 7:0 |
| dqm_hi_i | input | 1 | Mask for bits 15:8 |
| rd_data_o | output | 16 | Presented read word; masked or idle lanes are zero |
| rd_valid_o | output | 1 | A read beat is presented in this cycle |
| rd_lane_oe_o | output | 2 | Per-lane driver enable, bit 0 for the low byte |
| wr_lane_en_o | output | 2 | Per-lane write enable, bit 0 for the low byte |
| cas_err_o | output | 1 | The last sampled latency code was illegal |

## Verification
The assertions assume that read strobes and masks are only meaningful once the internal reset release has passed. They also assume that a lane mask sampled at an edge is meant for the beat presented two edges later, whatever latency is set. The checks on read timing rely on the latency freeze, which holds only because every beat in flight keeps the pipeline busy. The stimulus therefore changes the code only between beats or deliberately inside a burst, holds the masks low during reset, and waits for the synchronised release before issuing any strobe.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;

  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = 2;
  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = 3;

  localparam logic [2:0] CODE_LAT2 = 3'b010;
  localparam logic [2:0] CODE_LAT3 = 3'b011;

  function automatic logic code_legal(input logic [2:0] code);
    return (code == CODE_LAT2) || (code == CODE_LAT3);
  endfunction

endpackage

// File: rtl/dqp_rst_sync.sv
module dqp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/dqp_delay.sv
module dqp_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [DEPTH-1:0][W-1:0] chain;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] nxt;
    logic [W-1:0] r;
    if (i == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = chain[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r <= '0;
      else         r <= nxt;
    end
    assign chain[i] = r;
  end

  assign q_o = chain[DEPTH-1];

endmodule

// File: rtl/dqp_lat_cfg.sv
module dqp_lat_cfg
  import sdram_dq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,
  input  logic       idle_i,
  output logic       lat_sel_o,
  output logic       err_o
);

  logic lat_q, lat_d, lat_en;
  logic err_q, err_d;

  always_comb begin
    lat_en = idle_i & code_legal(code_i);
    lat_d  = (code_i == CODE_LAT3);
    err_d  = ~code_legal(code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (lat_en) lat_q <= lat_d;
      err_q <= err_d;
    end
  end

  assign lat_sel_o = lat_q;
  assign err_o     = err_q;

endmodule

// File: rtl/dqp_rd_out.sv
module dqp_rd_out #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned STAGES = 2,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [STAGES-1:0][DW:0]    taps_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [LANES-1:0]           mask_i,
  output logic [DW-1:0]              data_o,
  output logic                       valid_o,
  output logic [LANES-1:0]           oe_o
);

  logic [DW:0]      pick;
  logic [DW-1:0]    data_d, data_q;
  logic             valid_d, valid_q;
  logic [LANES-1:0] oe_d, oe_q;

  always_comb begin
    pick    = taps_i[sel_i];
    valid_d = pick[DW];
    for (int l = 0; l < LANES; l++) begin
      oe_d[l] = valid_d & ~mask_i[l];
      data_d[l*LANE_W +: LANE_W] = oe_d[l] ? pick[l*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      oe_q    <= '0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      oe_q    <= oe_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign oe_o    = oe_q;

endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
  import sdram_dq_pkg::*;
#(
  parameter int unsigned LANE_BITS   = LANE_W,
  parameter int unsigned RD_MASK_DLY = 2,
  localparam int unsigned DATA_W     = LANES * LANE_BITS,
  localparam int unsigned STAGES     = LAT_MAX - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cas_code_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  input  logic              wr_strobe_i,
  input  logic              dqm_lo_i,
  input  logic              dqm_hi_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [LANES-1:0]  rd_lane_oe_o,
  output logic [LANES-1:0]  wr_lane_en_o,
  output logic              cas_err_o
);

  logic                        rst_n_q;
  logic [LANES-1:0]            mask_now;
  logic [LANES-1:0]            mask_late;
  logic [STAGES-1:0][DATA_W:0] rd_tap;
  logic                        busy;
  logic                        lat_sel;

  dqp_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  assign mask_now = {dqm_hi_i, dqm_lo_i};

  // read beat pipeline: tap s holds a beat s+1 edges after its strobe
  for (genvar s = 0; s < STAGES; s++) begin : g_rd_stage
    logic [DATA_W:0] stage_in;
    if (s == 0) begin : g_first
      assign stage_in = {rd_strobe_i, arr_rdata_i};
    end else begin : g_next
      assign stage_in = rd_tap[s-1];
    end
    dqp_delay #(.W(DATA_W + 1), .DEPTH(1)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_n_q),
      .d_i    (stage_in),
      .q_o    (rd_tap[s])
    );
  end

  // read mask delay, independent of the latency
  dqp_delay #(.W(LANES), .DEPTH(RD_MASK_DLY)) u_mask_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .d_i    (mask_now),
    .q_o    (mask_late)
  );

  always_comb begin
    busy = rd_strobe_i;
    for (int s = 0; s < STAGES; s++) busy = busy | rd_tap[s][DATA_W];
  end

  dqp_lat_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_q),
    .code_i    (cas_code_i),
    .idle_i    (~busy),
    .lat_sel_o (lat_sel),
    .err_o     (cas_err_o)
  );

  dqp_rd_out #(.LANES(LANES), .LANE_W(LANE_BITS), .STAGES(STAGES)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .taps_i  (rd_tap),
    .sel_i   (lat_sel),
    .mask_i  (mask_late),
    .data_o  (rd_data_o),
    .valid_o (rd_valid_o),
    .oe_o    (rd_lane_oe_o)
  );

  // write masking acts in the same cycle
  for (genvar l = 0; l < LANES; l++) begin : g_wr_lane
    assign wr_lane_en_o[l] = wr_strobe_i & ~mask_now[l];
  end

endmodule

// File: rtl/sdram_dq_pipe_chk.sv
module sdram_dq_pipe_chk
  import sdram_dq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cas_code_i,
  input logic       rd_strobe_i,
  input logic       wr_strobe_i,
  input logic       dqm_lo_i,
  input logic       dqm_hi_i,
  input logic       lat_sel_i,
  input logic       rd_valid_o,
  input logic [1:0] rd_lane_oe_o,
  input logic [1:0] wr_lane_en_o,
  input logic       cas_err_o
);

  assert_cl2_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !lat_sel_i) |-> ##2 rd_valid_o);

  assert_cl3_timing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && lat_sel_i) |-> ##3 rd_valid_o);

  assert_oe_needs_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_lane_oe_o) |-> rd_valid_o);

  assert_rd_mask_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_lo_i |-> ##3 !rd_lane_oe_o[0]);

  assert_rd_mask_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_hi_i |-> ##3 !rd_lane_oe_o[1]);

  assert_wr_lo_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lane_en_o[0] |-> (wr_strobe_i && !dqm_lo_i));

  assert_wr_hi_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lane_en_o[1] |-> (wr_strobe_i && !dqm_hi_i));

  assert_err_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_legal(cas_code_i) |=> cas_err_o);

  assert_lat_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> $stable(lat_sel_i));

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_legal(cas_code_i) |=> !cas_err_o);

endmodule

bind sdram_dq_pipe sdram_dq_pipe_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_n_q),
  .cas_code_i   (cas_code_i),
  .rd_strobe_i  (rd_strobe_i),
  .wr_strobe_i  (wr_strobe_i),
  .dqm_lo_i     (dqm_lo_i),
  .dqm_hi_i     (dqm_hi_i),
  .lat_sel_i    (lat_sel),
  .rd_valid_o   (rd_valid_o),
  .rd_lane_oe_o (rd_lane_oe_o),
  .wr_lane_en_o (wr_lane_en_o),
  .cas_err_o    (cas_err_o)
);

// File: tb/sdram_dq_pipe_test.sv
module sdram_dq_pipe_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  code = 3'b000;
  logic        rd = 1'b0;
  logic [15:0] rdata = 16'h0000;
  logic        wr = 1'b0;
  logic        mlo = 1'b0;
  logic        mhi = 1'b0;
  logic [15:0] dq;
  logic        vld;
  logic [1:0]  oe;
  logic [1:0]  be;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sdram_dq_pipe uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cas_code_i   (code),
    .rd_strobe_i  (rd),
    .arr_rdata_i  (rdata),
    .wr_strobe_i  (wr),
    .dqm_lo_i     (mlo),
    .dqm_hi_i     (mhi),
    .rd_data_o    (dq),
    .rd_valid_o   (vld),
    .rd_lane_oe_o (oe),
    .wr_lane_en_o (be),
    .cas_err_o    (err)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        mlo;
    logic        mhi;
    logic [15:0] data;
    logic        ev;
    logic [1:0]  eoe;
    logic [15:0] edq;
    logic [1:0]  ebe;
  } vec_t;

  // latency two; row r strobe shows in row r+2, masked by row r-1 masks
  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 2'b00, 16'h0000, 2'b10},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'hA101, 1'b0, 2'b00, 16'h0000, 2'b00},
    '{1'b1, 1'b0, 1'b1, 1'b0, 16'hA102, 1'b0, 2'b00, 16'h0000, 2'b00},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'hA103, 1'b1, 2'b10, 16'hA100, 2'b00},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 2'b11, 16'hA102, 2'b01},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 2'b10, 16'hA100, 2'b11},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b00, 16'h0000, 2'b00},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b00, 16'h0000, 2'b00}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [15:0] d, input logic ml,
                       input logic mh, input logic w, input logic [2:0] c);
    rd = r; rdata = d; mlo = ml; mhi = mh; wr = w; code = c;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    #1;
    chk("R1", "valid in reset", {15'd0, vld}, 16'd0);
    chk("R1", "oe in reset", {14'd0, oe}, 16'd0);
    chk("R1", "data in reset", dq, 16'd0);
    chk("R1", "err in reset", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    repeat (4) step();
    #1;
    chk("R8", "err on reserved 000", {15'd0, err}, 16'd1);
    // R1: default latency two remains while the code is reserved
    drive(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 3'b000);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b000); #1;
    chk("R1", "not yet valid", {15'd0, vld}, 16'd0);
    step(); #1;
    chk("R1", "default lat2 valid", {15'd0, vld}, 16'd1);
    chk("R1", "default lat2 data", dq, 16'h1234);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b010); #1;
    chk("R4", "oe low without beat", {14'd0, oe}, 16'd0);
    step(); #1;
    chk("R10", "err cleared", {15'd0, err}, 16'd0);

    // vector table: R2, R4, R5, R6, R7
    for (int i = 0; i < 8; i++) begin
      step();
      drive(VEC[i].rd, VEC[i].data, VEC[i].mlo, VEC[i].mhi, VEC[i].wr, 3'b010);
      #1;
      chk("R2", "valid", {15'd0, vld}, {15'd0, VEC[i].ev});
      chk("R6", "lane oe", {14'd0, oe}, {14'd0, VEC[i].eoe});
      chk("R6", "data", dq, VEC[i].edq);
      chk("R7", "write enables", {14'd0, be}, {14'd0, VEC[i].ebe});
      chk("R10", "err", {15'd0, err}, 16'd0);
    end

    // R3: latency three
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b011);
    step(); drive(1'b1, 16'h5A3C, 1'b0, 1'b0, 1'b0, 3'b011);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b011); #1;
    chk("R3", "not at +1", {15'd0, vld}, 16'd0);
    step(); #1;
    chk("R3", "not at +2", {15'd0, vld}, 16'd0);
    step(); #1;
    chk("R3", "valid at +3", {15'd0, vld}, 16'd1);
    chk("R3", "data at +3", dq, 16'h5A3C);
    chk("R4", "both lanes on", {14'd0, oe}, 16'd3);
    step(); #1;
    chk("R4", "oe off after beat", {14'd0, oe}, 16'd0);

    // R5/R9: three-beat burst at latency three, code changed mid-burst
    step(); drive(1'b1, 16'hB001, 1'b0, 1'b0, 1'b0, 3'b011);
    step(); drive(1'b1, 16'hB002, 1'b0, 1'b0, 1'b0, 3'b010);
    step(); drive(1'b1, 16'hB003, 1'b0, 1'b0, 1'b0, 3'b010);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b010); #1;
    chk("R5", "beat 1 data", dq, 16'hB001);
    chk("R5", "beat 1 oe", {14'd0, oe}, 16'd3);
    step(); #1;
    chk("R5", "beat 2 data", dq, 16'hB002);
    chk("R9", "beat 2 still lat3", {15'd0, vld}, 16'd1);
    step(); #1;
    chk("R5", "beat 3 data", dq, 16'hB003);
    chk("R5", "beat 3 oe", {14'd0, oe}, 16'd3);
    step(); drive(1'b1, 16'hC001, 1'b0, 1'b0, 1'b0, 3'b010); #1;
    chk("R9", "burst drained", {15'd0, vld}, 16'd0);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b010); #1;
    chk("R9", "new lat not early", {15'd0, vld}, 16'd0);
    step(); #1;
    chk("R9", "new lat2 valid", {15'd0, vld}, 16'd1);
    chk("R9", "new lat2 data", dq, 16'hC001);

    // R8: reserved code keeps latency two
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b110);
    step(); drive(1'b1, 16'hD00D, 1'b0, 1'b0, 1'b0, 3'b110); #1;
    chk("R8", "err raised", {15'd0, err}, 16'd1);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b110); #1;
    chk("R8", "not yet valid", {15'd0, vld}, 16'd0);
    step(); #1;
    chk("R8", "lat kept at 2", dq, 16'hD00D);
    chk("R8", "err held", {15'd0, err}, 16'd1);
    step(); drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b011);
    step(); #1;
    chk("R10", "err cleared by 011", {15'd0, err}, 16'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule